// File: doc/BRIEF.md
# Channel Refresh Scheduler

The block services a bank of analog output channels through one shared converter. It walks round-robin through the channels, one channel per period of a refresh clock. On each visit it takes the selected channel's applied code, moves it toward that channel's target code by a bounded amount, and presents the result to the converter. The target codes come from an external register bank. Two single-cycle strobes frame each visit. The sample strobe marks the falling refresh edge, where the new code is captured. The hold strobe marks the following rising edge, where the channel's refresh switch opens.

The refresh clock comes from one of two sources. The first is an internal divider of the system clock. The second is an external level, synchronized from the input half of a bidirectional oscillator pin. In internal mode, with drive enabled, the block can drive its own refresh clock out on that pin, so that a second device can follow it. Because each visit moves a channel's code by a bounded amount, a large jump is spread over several full rounds. A busy flag stays high until every channel has reached its target.

Top module: `chan_refresh_sched`

## Requirements
- R1: While reset is low, conv_data and conv_ch are 0, both strobes are 0 and osc_pad_oe is 0. Every applied code starts at 0.
- R2: With clk_sel_ext low, the refresh clock period is 2*HALF_DIV system clocks. Exactly one sample strobe occurs per period, so consecutive sample strobes are 2*HALF_DIV cycles apart.
- R3: sample_stb pulses once per falling refresh edge. In that cycle conv_data carries the newly applied code of channel conv_ch. hold_stb pulses once at the next rising edge with the same conv_ch, HALF_DIV cycles after the sample strobe in internal mode. The two strobes are never high together.
- R4: Channels are visited in the order 0, 1, ..., NCH-1, then back to 0. conv_ch advances in the cycle after hold_stb.
- R5: On a visit, the applied code moves toward the target by the smaller of STEP and the remaining distance, and never passes the target. The target of channel i is target_flat[i*DW +: DW].
- R6: A change of D codes on one channel needs ceil(D/STEP) visits to that channel. busy is high whenever any applied code differs from its target, and low once all of them match.
- R7: With clk_sel_ext high, the refresh clock is osc_pad_i after a two-stage synchronizer. Sample strobes follow its falling edges and hold strobes follow its rising edges.
- R8: Changing clk_sel_ext produces no refresh edge in the cycle of the change. The visit order is not disturbed by a source switch.
- R9: osc_pad_oe rises only when clk_sel_ext is low and osc_drive_en is high, one cycle after those inputs. osc_pad_o carries the internal refresh clock, with a period of 2*HALF_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel_ext | input | 1 | 1 = external refresh clock, 0 = internal divider |
| osc_drive_en | input | 1 | Allows driving the internal clock onto the pin |
| osc_pad_i | input | 1 | Input half of the oscillator pin |
| osc_pad_o | output | 1 | Output half of the oscillator pin |
| osc_pad_oe | output | 1 | Output enable of the oscillator pin |
| target_flat | input | NCH*DW | Target codes, channel i at bits i*DW +: DW |
| conv_data | output | DW | Code presented to the shared converter |
| conv_ch | output | $clog2(NCH) | Channel currently served |
| sample_stb | output | 1 | Capture strobe at the falling refresh edge |
| hold_stb | output | 1 | Refresh-switch-open strobe at the rising edge |
| busy | output | 1 | Some applied code differs from its target |

## Verification
Assertions check the following on every cycle:
- the step limiter's result is at most STEP away from the current code and lies between the current code and the target;
- the slot index stays in range and advances by one, with wrap, after each hold strobe;
- rise and fall edges, and the two strobes, are never high together;
- no edge is produced in the cycle of a source switch;
- the pin enable stays low while the external source is held.

Only the bench scenarios can show:
- the refresh period and the sample-to-hold spacing in each clock mode;
- the number of visits a large rise or fall needs;
- the exact code sequence each visit produces;
- busy dropping when the last channel settles.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } rfs_src_e;
endpackage

// File: rtl/rfs_clk_src.sv
module rfs_clk_src
    import rfs_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  rfs_src_e src_sel,
    input  logic     drv_en,
    input  logic     pad_i,
    output logic     pad_o,
    output logic     pad_oe,
    output logic     rise_o,
    output logic     fall_o
);
    localparam int CNTW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNTW-1:0] CNT_TOP = CNTW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            int_clk;
        logic            sync1;
        logic            sync2;
        logic            prev;
        rfs_src_e        sel;
        logic            rise;
        logic            fall;
        logic            oe;
    } cs_t;

    cs_t st_d, st_q;
    logic lvl;
    logic same_src;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_TOP) begin
            st_d.cnt     = '0;
            st_d.int_clk = ~st_q.int_clk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.sync1 = pad_i;
        st_d.sync2 = st_q.sync1;
        lvl        = (src_sel == SRC_EXT) ? st_q.sync2 : st_q.int_clk;
        same_src   = (src_sel == st_q.sel);
        st_d.sel   = src_sel;
        st_d.prev  = lvl;
        st_d.rise  = same_src & lvl & ~st_q.prev;
        st_d.fall  = same_src & ~lvl & st_q.prev;
        st_d.oe    = (src_sel == SRC_INT) & drv_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.int_clk <= 1'b1;
            st_q.sync1   <= 1'b0;
            st_q.sync2   <= 1'b0;
            st_q.prev    <= 1'b1;
            st_q.sel     <= SRC_INT;
            st_q.rise    <= 1'b0;
            st_q.fall    <= 1'b0;
            st_q.oe      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pad_o  = st_q.int_clk;
    assign pad_oe = st_q.oe;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));
    a_r8_no_edge_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel != $past(src_sel)) |=> !(rise_o || fall_o));
    a_r9_oe_off_external: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_EXT && $past(src_sel) == SRC_EXT) |-> !pad_oe);
endmodule

// File: rtl/rfs_step.sv
module rfs_step #(
    parameter int DW   = 10,
    parameter int STEP = 64
) (
    input  logic [DW-1:0] cur_i,
    input  logic [DW-1:0] tgt_i,
    output logic [DW-1:0] nxt_o
);
    localparam logic [DW-1:0] STEP_V = DW'(STEP);

    logic          up;
    logic [DW-1:0] mag;

    always_comb begin
        up  = tgt_i > cur_i;
        mag = up ? (tgt_i - cur_i) : (cur_i - tgt_i);
        if (int'(mag) > STEP) begin
            nxt_o = up ? (cur_i + STEP_V) : (cur_i - STEP_V);
        end else begin
            nxt_o = tgt_i;
        end
    end
endmodule

// File: rtl/chan_refresh_sched.sv
module chan_refresh_sched
    import rfs_pkg::*;
#(
    parameter int NCH      = 10,
    parameter int DW       = 10,
    parameter int HALF_DIV = 4,
    parameter int STEP     = 64,
    localparam int CW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_sel_ext,
    input  logic            osc_drive_en,
    input  logic            osc_pad_i,
    output logic            osc_pad_o,
    output logic            osc_pad_oe,
    input  logic [NCH*DW-1:0] target_flat,
    output logic [DW-1:0]   conv_data,
    output logic [CW-1:0]   conv_ch,
    output logic            sample_stb,
    output logic            hold_stb,
    output logic            busy
);
    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] app;
        logic [CW-1:0]          slot;
        logic                   armed;
        logic [DW-1:0]          data;
        logic                   smp;
        logic                   hld;
    } sch_t;

    sch_t st_d, st_q;
    logic rise_e, fall_e;
    logic [DW-1:0] cur_sel, tgt_sel, stp_nxt;
    logic [NCH-1:0] differs;

    rfs_clk_src #(.HALF_DIV(HALF_DIV)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_sel(clk_sel_ext ? SRC_EXT : SRC_INT),
        .drv_en (osc_drive_en),
        .pad_i  (osc_pad_i),
        .pad_o  (osc_pad_o),
        .pad_oe (osc_pad_oe),
        .rise_o (rise_e),
        .fall_o (fall_e)
    );

    assign cur_sel = st_q.app[st_q.slot];
    assign tgt_sel = target_flat[int'(st_q.slot)*DW +: DW];

    rfs_step #(.DW(DW), .STEP(STEP)) u_step (
        .cur_i(cur_sel),
        .tgt_i(tgt_sel),
        .nxt_o(stp_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.smp = 1'b0;
        st_d.hld = 1'b0;
        if (st_q.hld) begin
            st_d.slot = (st_q.slot == LAST) ? '0 : st_q.slot + 1'b1;
        end
        if (fall_e) begin
            st_d.app[st_q.slot] = stp_nxt;
            st_d.data           = stp_nxt;
            st_d.smp            = 1'b1;
            st_d.armed          = 1'b1;
        end else if (rise_e && st_q.armed) begin
            st_d.hld   = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        assign differs[i] = st_q.app[i] != target_flat[i*DW +: DW];
    end

    assign busy       = |differs;
    assign conv_data  = st_q.data;
    assign conv_ch    = st_q.slot;
    assign sample_stb = st_q.smp;
    assign hold_stb   = st_q.hld;

    a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ch <= LAST);
    a_r4_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
        hold_stb |=> conv_ch == (($past(conv_ch) == LAST) ? '0 : $past(conv_ch) + 1'b1));
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && hold_stb));
    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ((stp_nxt >= cur_sel) ? int'(stp_nxt - cur_sel) : int'(cur_sel - stp_nxt)) <= STEP);
    a_r5_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel >= cur_sel) ? (stp_nxt >= cur_sel && stp_nxt <= tgt_sel)
                             : (stp_nxt <= cur_sel && stp_nxt >= tgt_sel));
endmodule

// File: tb/chan_refresh_sched_test.sv
module chan_refresh_sched_test;
    localparam int NCH = 10;
    localparam int DW = 10;
    localparam int HALF = 4;
    localparam int STEP = 64;
    localparam int CW = $clog2(NCH);

    logic clk = 0;
    logic rst_n = 0;
    logic clk_sel_ext = 0;
    logic osc_drive_en = 1;
    logic osc_pad_i = 0;
    logic osc_pad_o, osc_pad_oe;
    logic [NCH*DW-1:0] target_flat = '0;
    logic [DW-1:0] conv_data;
    logic [CW-1:0] conv_ch;
    logic sample_stb, hold_stb, busy;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int model [NCH];
    int visits [NCH];
    int n_samp = 0, last_samp_cyc = 0, gap_samp = 0, gap_hold = 0;
    int exp_ch = 0, last_ch = 0;
    bit ext_run = 0;
    bit done = 0;

    chan_refresh_sched #(.NCH(NCH), .DW(DW), .HALF_DIV(HALF), .STEP(STEP)) uut (
        .clk(clk), .rst_n(rst_n), .clk_sel_ext(clk_sel_ext),
        .osc_drive_en(osc_drive_en), .osc_pad_i(osc_pad_i),
        .osc_pad_o(osc_pad_o), .osc_pad_oe(osc_pad_oe),
        .target_flat(target_flat), .conv_data(conv_data), .conv_ch(conv_ch),
        .sample_stb(sample_stb), .hold_stb(hold_stb), .busy(busy)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bstep(input int cur, input int t);
        if (t > cur) return (t - cur > STEP) ? cur + STEP : t;
        return (cur - t > STEP) ? cur - STEP : t;
    endfunction

    function automatic int tgt_of(input int ch);
        return int'(target_flat[ch*DW +: DW]);
    endfunction

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    // Visit monitor: channel order (R4, R8), stepped code (R5), hold pairing (R3)
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_stb) begin
                chk(int'(conv_ch) == exp_ch, "R4 R8 visit order", int'(conv_ch), exp_ch);
                begin
                    int e;
                    e = bstep(model[conv_ch], tgt_of(int'(conv_ch)));
                    chk(int'(conv_data) == e, "R5 stepped code", int'(conv_data), e);
                    model[conv_ch] = e;
                end
                visits[conv_ch]++;
                n_samp++;
                gap_samp = cyc - last_samp_cyc;
                last_samp_cyc = cyc;
                last_ch = int'(conv_ch);
                exp_ch = (int'(conv_ch) == NCH - 1) ? 0 : int'(conv_ch) + 1;
            end
            if (hold_stb) begin
                chk(int'(conv_ch) == last_ch, "R3 hold channel", int'(conv_ch), last_ch);
                gap_hold = cyc - last_samp_cyc;
            end
        end
    end

    initial begin
        forever begin
            int k;
            @(negedge clk);
            if (ext_run) begin
                for (k = 0; k < 9; k++) @(negedge clk);
                osc_pad_i = ~osc_pad_i;
            end
        end
    end

    task automatic wait_samples(input int n);
        int goal;
        goal = n_samp + n;
        while (n_samp < goal) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_tgt(input int ch, input int v);
        target_flat[ch*DW +: DW] = DW'(v);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk(conv_data == 0, "R1 conv_data", int'(conv_data), 0);
        chk(conv_ch == 0, "R1 conv_ch", int'(conv_ch), 0);
        chk(!sample_stb && !hold_stb, "R1 strobes", int'(sample_stb) + int'(hold_stb), 0);
        chk(!osc_pad_oe, "R1 pad hi-z", int'(osc_pad_oe), 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0, "R1 applied zero", int'(busy), 0);
    endtask

    task automatic t_small;
        set_tgt(3, 30);
        set_tgt(7, 5);
        wait_samples(12);
        chk(busy == 0, "R6 settled after small change", int'(busy), 0);
        chk(model[3] == 30, "R5 ch3 reached", model[3], 30);
    endtask

    task automatic t_timing;
        wait_samples(3);
        chk(gap_samp == 2 * HALF, "R2 refresh period", gap_samp, 2 * HALF);
        chk(gap_hold == HALF, "R3 sample to hold", gap_hold, HALF);
    endtask

    task automatic t_large(input int v, input int exp_visits);
        int v0;
        v0 = visits[0];
        set_tgt(0, v);
        @(negedge clk);
        chk(busy == 1, "R6 busy raised", int'(busy), 1);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(visits[0] - v0 == exp_visits, "R6 visits needed", visits[0] - v0, exp_visits);
        chk(model[0] == v, "R5 final code", model[0], v);
    endtask

    task automatic t_pad;
        int r1, r2;
        clk_sel_ext = 0;
        osc_drive_en = 1;
        @(negedge clk);
        @(negedge clk);
        chk(osc_pad_oe == 1, "R9 oe internal", int'(osc_pad_oe), 1);
        osc_drive_en = 0;
        @(negedge clk);
        @(negedge clk);
        chk(osc_pad_oe == 0, "R9 oe drive off", int'(osc_pad_oe), 0);
        osc_drive_en = 1;
        while (osc_pad_o) @(negedge clk);
        while (!osc_pad_o) @(negedge clk);
        r1 = cyc;
        while (osc_pad_o) @(negedge clk);
        while (!osc_pad_o) @(negedge clk);
        r2 = cyc;
        chk(r2 - r1 == 2 * HALF, "R9 pad clock period", r2 - r1, 2 * HALF);
    endtask

    task automatic t_ext;
        ext_run = 1;
        clk_sel_ext = 1;
        @(negedge clk);
        @(negedge clk);
        chk(osc_pad_oe == 0, "R9 oe external", int'(osc_pad_oe), 0);
        wait_samples(4);
        chk(gap_samp == 20, "R7 external period", gap_samp, 20);
        chk(gap_hold == 10, "R7 external hold spacing", gap_hold, 10);
        clk_sel_ext = 0;
        ext_run = 0;
        wait_samples(4);
        chk(gap_samp == 2 * HALF, "R8 back to internal", gap_samp, 2 * HALF);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            model[i] = 0;
            visits[i] = 0;
        end
        t_reset();
        t_small();
        t_timing();
        t_large(1000, 16);
        t_large(10, 16);
        t_pad();
        t_ext();
        set_tgt(9, 700);
        set_tgt(2, 65);
        wait_samples(NCH * 12);
        chk(busy == 0, "R6 multi-channel settle", int'(busy), 0);
        done = 1;
        summary();
    end
endmodule